// File: doc/BRIEF.md
# Bridge Transaction Ordering Queue

This block sits inside a bus bridge and holds up to eight pending transactions of five kinds: posted writes, delayed read and write requests, and delayed read and write completions. Each entry carries a type code and an opaque tag that points at payload kept elsewhere. The queue keeps the entries in arrival order. In each cycle it picks one entry to hand to its consumer.

The consumer gives a per-type ready mask. An entry is a candidate when its type is ready and the ordering rules let it go ahead of every older entry still in the queue. The oldest candidate leaves in that cycle. The remaining entries close up behind it, so age order is kept. Where no entry may move, the queue holds. A transaction that waits behind a blocked one therefore goes ahead only where doing so keeps the order that software sees.

Top module: `txn_order_queue`

## Requirements
- R1: After reset the queue is empty: `full` and `deq_valid` are low.
- R2: Type codes are posted write = 0, delayed read request = 1, delayed write request = 2, delayed read completion = 3, delayed write completion = 4. An enqueue with code 5, 6 or 7 is dropped.
- R3: The queue holds 8 entries. `full` is high exactly when 8 are held, and an enqueue while `full` is high is dropped, even in a cycle where an entry leaves.
- R4: An entry can leave only when bit `t` of `sink_ready` is set, where `t` is its type code. `deq_valid` high means that the entry shown on `deq_type`/`deq_tag` is removed at that clock edge. At most one entry leaves per cycle.
- R5: An entry never goes ahead of an older entry of the same type, so each type leaves in arrival order.
- R6: A posted write may go ahead of older delayed read requests, delayed write requests and delayed write completions. It may not go ahead of older posted writes or delayed read completions.
- R7: A delayed read or write request may go ahead of an older delayed write completion only. It waits behind any older posted write, request or read completion.
- R8: A delayed read completion may go ahead of older delayed read or write requests. It waits behind older posted writes, read completions and write completions.
- R9: A delayed write completion may go ahead of older posted writes, read requests and write requests. It waits behind older read completions and write completions.
- R10: Among the entries allowed to leave, the oldest is chosen.
- R11: An enqueue and a dequeue in the same cycle both take effect. The new entry becomes the youngest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid | input | 1 | Enqueue request |
| enq_type | input | 3 | Type code of the new entry |
| enq_tag | input | TAG_W | Tag of the new entry |
| full | output | 1 | Queue holds DEPTH entries |
| sink_ready | input | 5 | Per-type consumer readiness, bit index = type code |
| deq_valid | output | 1 | Selected entry is removed this cycle |
| deq_type | output | 3 | Type of the selected entry |
| deq_tag | output | TAG_W | Tag of the selected entry |

## Verification
Directed pairs load one older and one newer entry. The ready mask then enables only the newer type, so the result shows whether that type pair is allowed to pass or must wait. The pairs that must pass are checked separately from those that must block, and for every type. Fill and drain runs test the full boundary, dropped enqueues and in-order leaving. Random traffic with random type mixes and sparse ready masks tests oldest-candidate choice over deeper queues, and it covers simultaneous enqueue and dequeue.

// File: rtl/txn_order_queue.sv
module txn_order_queue #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  input  logic [2:0]       enq_type,
  input  logic [TAG_W-1:0] enq_tag,
  output logic             full,
  input  logic [4:0]       sink_ready,
  output logic             deq_valid,
  output logic [2:0]       deq_type,
  output logic [TAG_W-1:0] deq_tag
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [2:0]       typ [DEPTH];
  logic [TAG_W-1:0] tg  [DEPTH];
  logic [CNT_W-1:0] count;
  logic [IDX_W-1:0] sel;
  logic [DEPTH-1:0] elig;
  logic             push;
  logic [CNT_W-1:0] wr_idx;

  function automatic logic may_pass(input logic [2:0] yng, input logic [2:0] old);
    case (yng)
      3'd0:        may_pass = (old == 3'd1) || (old == 3'd2) || (old == 3'd4);
      3'd1, 3'd2:  may_pass = (old == 3'd4);
      3'd3:        may_pass = (old == 3'd1) || (old == 3'd2);
      3'd4:        may_pass = (old <= 3'd2);
      default:     may_pass = 1'b0;
    endcase
  endfunction

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      elig[i] = (i < int'(count)) && sink_ready[typ[i]];
      for (int j = 0; j < i; j++)
        if (!may_pass(typ[i], typ[j])) elig[i] = 1'b0;
    end
    sel = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (elig[i]) sel = IDX_W'(i);
  end

  assign deq_valid = |elig;
  assign deq_type  = typ[sel];
  assign deq_tag   = tg[sel];
  assign full      = (count == CNT_W'(DEPTH));
  assign push      = enq_valid && !full && (enq_type <= 3'd4);
  assign wr_idx    = count - CNT_W'(deq_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      count <= count + CNT_W'(push) - CNT_W'(deq_valid);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH - 1; i++)
      if (deq_valid && i >= int'(sel)) begin
        typ[i] <= typ[i+1];
        tg[i]  <= tg[i+1];
      end
    for (int i = 0; i < DEPTH; i++)
      if (push && i == int'(wr_idx)) begin
        typ[i] <= enq_type;
        tg[i]  <= enq_tag;
      end
  end
endmodule

// File: rtl/txn_order_queue_chk.sv
module txn_order_queue_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enq_valid,
  input logic [2:0]       enq_type,
  input logic             full,
  input logic [4:0]       sink_ready,
  input logic             deq_valid,
  input logic [2:0]       deq_type,
  input logic [CNT_W-1:0] count
);
  a_r4_ready_respected: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid |-> (deq_type <= 3'd4) && sink_ready[deq_type]);

  a_r1_empty_no_deq: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !deq_valid);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !deq_valid) |=> full && $stable(count));

  a_r2_bad_code_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && enq_type > 3'd4 && !deq_valid) |=> $stable(count));

  a_r11_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && !full && enq_type <= 3'd4 && deq_valid) |=> $stable(count));
endmodule

bind txn_order_queue txn_order_queue_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_type(enq_type),
  .full(full), .sink_ready(sink_ready), .deq_valid(deq_valid),
  .deq_type(deq_type), .count(count)
);

// File: tb/txn_order_queue_test.sv
`timescale 1ns/1ps
module txn_order_queue_test;
  logic       clk = 0, rst_n = 0;
  logic       enq_valid = 0;
  logic [2:0] enq_type = 0;
  logic [7:0] enq_tag = 0;
  logic [4:0] sink_ready = 0;
  logic       full, deq_valid;
  logic [2:0] deq_type;
  logic [7:0] deq_tag;

  int checks = 0, failures = 0;
  int mt [8];
  int mg [8];
  int mc = 0;
  logic ov; logic [2:0] ot; logic [7:0] otag; logic ofull;
  logic [7:0] tagc = 1;

  txn_order_queue uut (.clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_type(enq_type),
    .enq_tag(enq_tag), .full(full), .sink_ready(sink_ready), .deq_valid(deq_valid),
    .deq_type(deq_type), .deq_tag(deq_tag));

  always #4 clk = ~clk;

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic bit ok_pass(int y, int o);
    case (y)
      0: return o == 1 || o == 2 || o == 4;
      1, 2: return o == 4;
      3: return o == 1 || o == 2;
      4: return o <= 2;
      default: return 0;
    endcase
  endfunction

  function automatic int pick(logic [4:0] rdy);
    for (int i = 0; i < mc; i++) begin
      bit e = rdy[mt[i]];
      for (int j = 0; j < i; j++) if (!ok_pass(mt[i], mt[j])) e = 0;
      if (e) return i;
    end
    return -1;
  endfunction

  task automatic check(bit cond, string req, int act, int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit ev, int et, logic [4:0] rdy, string req);
    int p;
    @(negedge clk);
    enq_valid = ev; enq_type = 3'(et); enq_tag = tagc; sink_ready = rdy;
    #1;
    ov = deq_valid; ot = deq_type; otag = deq_tag; ofull = full;
    p = pick(rdy);
    check(ov == (p >= 0), req, ov, p >= 0);
    if (p >= 0 && ov) begin
      check(ot == 3'(mt[p]) && otag == 8'(mg[p]), req, {ot, otag}, {3'(mt[p]), 8'(mg[p])});
    end
    check(ofull == (mc == 8), "R3", ofull, mc == 8);
    if (p >= 0) begin
      for (int i = p; i < mc - 1; i++) begin mt[i] = mt[i+1]; mg[i] = mg[i+1]; end
      mc--;
    end
    if (ev && !(mc + (p >= 0) == 8) && et <= 4) begin
      mt[mc] = et; mg[mc] = tagc; mc++;
    end
    tagc++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; enq_valid = 0; sink_ready = 0;
    repeat (2) @(negedge clk);
    #1;
    check(!full && !deq_valid, "R1", {full, deq_valid}, 0);
    rst_n = 1; mc = 0;
  endtask

  task automatic pair(int o, int y, bit exp_v, string req);
    do_reset();
    step(1, o, 0, req);
    step(1, y, 0, req);
    step(0, 0, 5'(1 << y), req);
    check(ov == exp_v, req, ov, exp_v);
    if (exp_v) check(ot == 3'(y), req, ot, y);
  endtask

  initial begin
    process::self().srandom(32'h5eed);
    do_reset();
    pair(3, 0, 0, "R6"); pair(1, 0, 1, "R6"); pair(4, 0, 1, "R6");
    pair(0, 1, 0, "R7"); pair(4, 2, 1, "R7"); pair(3, 2, 0, "R7");
    pair(1, 3, 1, "R8"); pair(4, 3, 0, "R8"); pair(0, 3, 0, "R8");
    pair(0, 4, 1, "R9"); pair(3, 4, 0, "R9"); pair(2, 4, 1, "R9");
    pair(1, 1, 1, "R5");
    check(otag == 8'(tagc - 3), "R5", otag, tagc - 3);
    do_reset();
    step(1, 6, 0, "R2");
    step(0, 0, 0, "R2");
    check(!ov, "R2", ov, 0);
    do_reset();
    for (int i = 0; i < 9; i++) step(1, i % 5, 0, "R3");
    check(ofull, "R3", ofull, 1);
    step(1, 0, 5'h1f, "R3");
    for (int i = 0; i < 9; i++) step(0, 0, 5'h1f, "R10");
    check(!ov, "R3", ov, 0);
    do_reset();
    step(1, 1, 0, "R11");
    step(1, 0, 5'h02, "R11");
    step(0, 0, 5'h1f, "R11");
    check(ov && ot == 3'd0, "R11", ot, 0);
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, $urandom % 6, 5'($urandom & $urandom), "R10");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule